// File: doc/BRIEF.md
# Transition-Pulse Isolation Encoder

This block is the sending half of a single-channel digital isolation link. It watches one logic input and turns its level changes into single-cycle pulses on two lines: a "set" line that fires when the input becomes high and a "clear" line that fires when it becomes low. A receiver that holds nothing but a set/reset latch can rebuild the input level from these pulses.

Pulses can be lost, and the receiver may power up after the sender. To cover both cases, the encoder re-sends the present level whenever the input has been quiet for a programmable number of cycles. It keeps doing this for as long as the input stays idle, so the far-side latch stays correct at DC. A hold input and a supply-good flag stop all pulse output while they are active. When emission is allowed again, the encoder at once sends a pulse for the present level, so the receiver recovers without waiting for a refresh. The input is brought into the clock domain by a synchronizer before any edge is detected.

Top module: `iso_pulse_encoder`

## Requirements
- R1: A rising input level, once synchronized, produces exactly one pulse on `set_pulse`. If the input changes just after clock edge k, the pulse is high in the cycle after edge k+3 (two synchronizer stages plus one output register).
- R2: A falling input level produces exactly one pulse on `clr_pulse`, with the same latency as R1.
- R3: Every pulse on either line is exactly one clock cycle wide.
- R4: While the input level is unchanged, a refresh pulse for that level (set for 1, clear for 0) is emitted every `REFRESH_CYCLES` cycles, counted from the previous pulse.
- R5: Every pulse, whether from an edge, a refresh or a resume, restarts the refresh interval. A pending refresh of the old level is never emitted after an edge. An edge that falls in the same cycle as a due refresh gives one pulse, for the new level only.
- R6: While `hold_off` is 1, both outputs stay 0 from the next cycle on, and input changes produce no pulse.
- R7: While `supply_ok` is 0, both outputs stay 0 from the next cycle on, and input changes produce no pulse.
- R8: When emission becomes allowed again (`hold_off` low and `supply_ok` high), a pulse for the present synchronized level appears in the cycle after the first clock edge that sees the allowed state.
- R9: `set_pulse` and `clr_pulse` are never high in the same cycle.
- R10: While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 1 | Asynchronous logic input to be carried across the link |
| hold_off | input | 1 | 1 stops all pulse emission |
| supply_ok | input | 1 | 1 when the input-side supply is good; 0 stops all pulse emission |
| set_pulse | output | 1 | One-cycle pulse: the input is now high |
| clr_pulse | output | 1 | One-cycle pulse: the input is now low |

## Verification
An input edge and an expiring refresh interval can land in the same cycle. The bench provokes this by timing an input change so that its synchronized edge arrives exactly `REFRESH_CYCLES` cycles after the last pulse. It then requires a single pulse, for the new level, in that cycle, no pulse of the old level, and the next refresh one full interval later. A resume and a pending input change can also coincide. The hold and supply tests toggle the input while emission is stopped and then check that the resume pulse carries the final level.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_SET  = 2'd1,
    PK_CLR  = 2'd2
  } pulse_kind_e;
endpackage

// File: rtl/pe_sync.sv
module pe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pe_refresh_timer.sv
module pe_refresh_timer #(
  parameter int INTERVAL = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic due
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // count stalls at LAST until a restart arrives
  always_comb begin
    cnt_en = restart || (cnt_q != LAST);
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign due = (cnt_q == LAST);

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !due);
endmodule

// File: rtl/pe_pulse_gen.sv
module pe_pulse_gen
  import pe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic active,
  input  logic due,
  output logic issue,
  output logic set_q,
  output logic clr_q
);
  logic        lvl_q, act_q;
  logic        edge_c, resume_c;
  pulse_kind_e kind_d;
  logic        set_d, clr_d;

  always_comb begin
    edge_c   = level ^ lvl_q;
    resume_c = active & ~act_q;
    issue    = active & (edge_c | resume_c | due);
    if (!issue)     kind_d = PK_NONE;
    else if (level) kind_d = PK_SET;
    else            kind_d = PK_CLR;
    set_d = (kind_d == PK_SET);
    clr_d = (kind_d == PK_CLR);
  end

  // level tracker runs even while stopped, so no stale edge appears later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      act_q <= 1'b0;
      set_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      lvl_q <= level;
      act_q <= active;
      set_q <= set_d;
      clr_q <= clr_d;
    end
  end

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_q && clr_q));

  a_r3_set_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    set_q |=> !set_q);

  a_r3_clr_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);

  a_r6_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!set_q && !clr_q));
endmodule

// File: rtl/iso_pulse_encoder.sv
module iso_pulse_encoder #(
  parameter int SYNC_STAGES    = 2,
  parameter int REFRESH_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_in,
  input  logic hold_off,
  input  logic supply_ok,
  output logic set_pulse,
  output logic clr_pulse
);
  logic sync_level;
  logic active;
  logic issue;
  logic due;
  logic tmr_restart;

  assign active      = ~hold_off & supply_ok;
  assign tmr_restart = issue | ~active;

  pe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (data_in),
    .q_sync  (sync_level)
  );

  pe_refresh_timer #(.INTERVAL(REFRESH_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .due     (due)
  );

  pe_pulse_gen u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (sync_level),
    .active (active),
    .due    (due),
    .issue  (issue),
    .set_q  (set_pulse),
    .clr_q  (clr_pulse)
  );

  a_r1_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sync_level) && active) |=> set_pulse);

  a_r2_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sync_level) && active) |=> clr_pulse);

  a_r8_resume_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hold_off) && supply_ok) |=> (set_pulse || clr_pulse));

  a_r10_reset_low: assert property (@(posedge clk)
    !rst_n |-> (!set_pulse && !clr_pulse));
endmodule

// File: tb/iso_pulse_encoder_test.sv
module iso_pulse_encoder_test;
  localparam int RFR = 40;

  logic clk = 1'b0;
  logic rst_n, data_in, hold_off, supply_ok;
  logic set_pulse, clr_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int set_cnt = 0, clr_cnt = 0, last_set = -1, last_clr = -1;
  int both_cnt = 0, wide_cnt = 0;
  logic prev_set = 1'b0, prev_clr = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  iso_pulse_encoder #(.SYNC_STAGES(2), .REFRESH_CYCLES(RFR)) uut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .hold_off(hold_off),
    .supply_ok(supply_ok), .set_pulse(set_pulse), .clr_pulse(clr_pulse)
  );

  // pulse monitor, samples between rising edges
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (set_pulse) begin set_cnt = set_cnt + 1; last_set = cyc; end
    if (clr_pulse) begin clr_cnt = clr_cnt + 1; last_clr = cyc; end
    if (set_pulse && clr_pulse) both_cnt = both_cnt + 1;
    if ((set_pulse && prev_set) || (clr_pulse && prev_clr)) wide_cnt = wide_cnt + 1;
    prev_set = set_pulse;
    prev_clr = clr_pulse;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; data_in = 1'b0; hold_off = 1'b1; supply_ok = 1'b1;
    repeat (4) tick();
    chk(!set_pulse && !clr_pulse, "R10 outputs low in reset", {set_pulse, clr_pulse}, 0);
    rst_n = 1'b1;
    repeat (20) tick();
    chk(set_cnt + clr_cnt == 0, "R6 no pulse while held after reset", set_cnt + clr_cnt, 0);
  endtask

  task automatic t_resume_low();
    int c0, s0;
    c0 = cyc; s0 = clr_cnt;
    hold_off = 1'b0;
    repeat (4) tick();
    chk(clr_cnt == s0 + 1, "R8 one resume pulse at level 0", clr_cnt - s0, 1);
    chk(last_clr == c0 + 2, "R8 resume pulse timing", last_clr, c0 + 2);
  endtask

  task automatic t_rise();
    int c0, s0;
    repeat (15) tick();
    c0 = cyc; s0 = set_cnt;
    data_in = 1'b1;
    repeat (8) tick();
    chk(set_cnt == s0 + 1, "R1 one set pulse on rise", set_cnt - s0, 1);
    chk(last_set == c0 + 4, "R1 set pulse latency", last_set, c0 + 4);
  endtask

  task automatic t_refresh_high();
    int e, s0, k0;
    e = last_set; s0 = set_cnt; k0 = clr_cnt;
    wait_until(e + 2*RFR + 2);
    chk(set_cnt == s0 + 2, "R4 two refresh set pulses", set_cnt - s0, 2);
    chk(last_set == e + 2*RFR, "R4 refresh spacing", last_set, e + 2*RFR);
    chk(clr_cnt == k0, "R4 no clear pulse at level 1", clr_cnt - k0, 0);
  endtask

  task automatic t_fall();
    int c0, k0;
    c0 = cyc; k0 = clr_cnt;
    data_in = 1'b0;
    repeat (8) tick();
    chk(clr_cnt == k0 + 1, "R2 one clear pulse on fall", clr_cnt - k0, 1);
    chk(last_clr == c0 + 4, "R2 clear pulse latency", last_clr, c0 + 4);
  endtask

  task automatic t_restart();
    int c0, s0, k0, g;
    wait_until(last_clr + RFR/2);
    c0 = cyc; s0 = set_cnt; k0 = clr_cnt;
    data_in = 1'b1;
    g = c0 + 4;
    wait_until(g + RFR + 2);
    chk(set_cnt == s0 + 2, "R5 edge then one refresh", set_cnt - s0, 2);
    chk(last_set == g + RFR, "R5 refresh counted from edge", last_set, g + RFR);
    chk(clr_cnt == k0, "R5 old-level refresh dropped", clr_cnt - k0, 0);
  endtask

  task automatic t_collide();
    int p, c0, s0, k0;
    p = last_set;
    wait_until(p + RFR - 4);
    c0 = cyc; s0 = set_cnt; k0 = clr_cnt;
    data_in = 1'b0;
    wait_until(p + 2*RFR + 2);
    chk(set_cnt == s0, "R5 no old-level pulse at collision", set_cnt - s0, 0);
    chk(clr_cnt == k0 + 2, "R5 collision gives single new-level pulse", clr_cnt - k0, 2);
    chk(last_clr == p + 2*RFR, "R5 refresh after collision", last_clr, p + 2*RFR);
  endtask

  task automatic t_hold();
    int c0, s0, k0;
    hold_off = 1'b1;
    repeat (2) tick();
    s0 = set_cnt; k0 = clr_cnt;
    data_in = 1'b1; repeat (12) tick();
    data_in = 1'b0; repeat (12) tick();
    data_in = 1'b1; repeat (3*RFR) tick();
    chk(set_cnt + clr_cnt == s0 + k0, "R6 silent while held", set_cnt + clr_cnt - s0 - k0, 0);
    c0 = cyc;
    hold_off = 1'b0;
    repeat (4) tick();
    chk(set_cnt == s0 + 1 && clr_cnt == k0, "R8 resume pulse for level 1", set_cnt - s0, 1);
    chk(last_set == c0 + 2, "R8 resume timing after hold", last_set, c0 + 2);
  endtask

  task automatic t_supply();
    int c0, s0, k0;
    supply_ok = 1'b0;
    repeat (2) tick();
    s0 = set_cnt; k0 = clr_cnt;
    data_in = 1'b0; repeat (12) tick();
    data_in = 1'b1; repeat (12) tick();
    data_in = 1'b0; repeat (3*RFR) tick();
    chk(set_cnt + clr_cnt == s0 + k0, "R7 silent while supply low", set_cnt + clr_cnt - s0 - k0, 0);
    c0 = cyc;
    supply_ok = 1'b1;
    repeat (4) tick();
    chk(clr_cnt == k0 + 1 && set_cnt == s0, "R7 resume pulse for level 0", clr_cnt - k0, 1);
    chk(last_clr == c0 + 2, "R8 resume timing after supply", last_clr, c0 + 2);
  endtask

  initial begin
    t_reset();
    t_resume_low();
    t_rise();
    t_refresh_high();
    t_fall();
    t_restart();
    t_collide();
    t_hold();
    t_supply();
    repeat (5) tick();
    chk(both_cnt == 0, "R9 never both high", both_cnt, 0);
    chk(wide_cnt == 0, "R3 pulses one cycle wide", wide_cnt, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule